// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a very small processor that executes programs held in its own 32-word, 32-bit store. Its architectural state is an accumulator, a 5-bit instruction counter and a register that holds the word most recently fetched. It runs one instruction per clock. In each step the counter is first advanced, modulo 32. The word at the new counter value is then fetched, and that word's function field chooses between an indirect jump, an indirect relative jump, load-negated, store, subtract, skip-if-negative and stop.

A testbench or host uses the debug side of the block while the processor is halted. It can deposit words into the store, read any word back at any time, and preload the counter. A start pulse sets the processor running. The processor halts again on a stop instruction, or when an enabled breakpoint address equals the counter at the beginning of a step. A two-bit code reports which of these two events caused the most recent halt.

Top module: `acc_cpu`

## Requirements
- R1: After reset the block is halted, `halt_why` is 00, and `acc`, `ctr` and `pres` are zero. Every storage word reads back as zero.
- R2: A `start` pulse while halted clears `halt_why` and starts execution at the next clock, one instruction per clock. Each step first sets the counter to counter+1 modulo 32. It then loads the word at that address into `pres`. The function code is in word bits 15:13 and the address field is in bits 4:0.
- R3: Function 000 loads the counter with bits 4:0 of the word stored at the address field. Function 001 adds bits 4:0 of that word to the incremented counter, modulo 32.
- R4: Function 010 loads the accumulator with the two's complement negation of the addressed word. Function 011 writes the accumulator into the addressed word.
- R5: Functions 100 and 101 both subtract the addressed word from the accumulator, modulo 2^32.
- R6: Function 110 ignores its address field. It adds one more to the incremented counter only when accumulator bit 31 is set, which skips the next instruction.
- R7: Function 111 halts the block with `halt_why` = 01. The counter is left at the stop instruction's own address.
- R8: At the beginning of a step, when `bp_en` is high and the counter equals `bp_addr`, the block halts with `halt_why` = 10. No fetch takes place, and the counter, accumulator and `pres` are unchanged. The first step after `start` skips this check, so execution can resume from a breakpoint.
- R9: `dbg_rdata` always shows the word at `dbg_addr`. `dbg_we` writes `dbg_wdata` into that word only while halted; while running it has no effect.
- R10: `ctr_ld` loads `ctr_val` into the counter only while halted; while running it has no effect.
- R11: A deposit and a counter load that coincide with `start` both take effect. The first step after that start then uses the loaded counter and the deposited word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution when halted |
| bp_en | input | 1 | Breakpoint enable |
| bp_addr | input | 5 | Breakpoint counter value |
| dbg_we | input | 1 | Deposit strobe (honoured while halted) |
| dbg_addr | input | 5 | Deposit / examine address |
| dbg_wdata | input | 32 | Deposit data |
| dbg_rdata | output | 32 | Examine data, word at `dbg_addr` |
| ctr_ld | input | 1 | Counter load strobe (honoured while halted) |
| ctr_val | input | 5 | Counter load value |
| halted | output | 1 | High while the processor is not executing |
| halt_why | output | 2 | 00 none, 01 stop instruction, 10 breakpoint |
| acc | output | 32 | Accumulator |
| ctr | output | 5 | Instruction counter |
| pres | output | 32 | Most recently fetched instruction word |

## Verification
Three things can land on the same halted clock edge: the start pulse, a deposit and a counter load. The bench drives all three in one cycle. The loaded counter points just below the word being deposited, that word is a stop instruction, and it replaces a load-negated. A correct block therefore stops one step later, at the loaded address plus one, with the accumulator unchanged. A block that drops the deposit or the counter load would instead run a different instruction or fetch from the old counter value. A second kind of overlap, a breakpoint that matches the counter in the same cycle as a resume, is judged by whether the block takes exactly one step before stopping on the following instruction.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5,
  parameter int OP_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bp_en,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [WORD_W-1:0] dbg_wdata,
  output logic [WORD_W-1:0] dbg_rdata,
  input  logic              ctr_ld,
  input  logic [ADDR_W-1:0] ctr_val,
  output logic              halted,
  output logic [1:0]        halt_why,
  output logic [WORD_W-1:0] acc,
  output logic [ADDR_W-1:0] ctr,
  output logic [WORD_W-1:0] pres
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] WHY_NONE = 2'b00;
  localparam logic [1:0] WHY_STOP = 2'b01;
  localparam logic [1:0] WHY_BP   = 2'b10;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              run_q, first_q;
  logic [1:0]        why_q;
  logic [WORD_W-1:0] acc_q, pres_q;
  logic [ADDR_W-1:0] ctr_q;

  wire [ADDR_W-1:0] nxt    = ctr_q + ADDR_W'(1);
  wire [WORD_W-1:0] fetch  = mem[nxt];
  wire [2:0]        op     = fetch[OP_LSB+2:OP_LSB];
  wire [ADDR_W-1:0] ea     = fetch[ADDR_W-1:0];
  wire [WORD_W-1:0] opnd   = mem[ea];
  wire              bp_hit = run_q && !first_q && bp_en && (ctr_q == bp_addr);
  wire              step   = run_q && !bp_hit;
  wire              neg    = acc_q[WORD_W-1];

  assign dbg_rdata = mem[dbg_addr];
  assign halted    = !run_q;
  assign halt_why  = why_q;
  assign acc       = acc_q;
  assign ctr       = ctr_q;
  assign pres      = pres_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (step && op == 3'b011) begin
      mem[ea] <= acc_q;
    end else if (!run_q && dbg_we) begin
      mem[dbg_addr] <= dbg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
      why_q   <= WHY_NONE;
      acc_q   <= '0;
      ctr_q   <= '0;
      pres_q  <= '0;
    end else if (!run_q) begin
      if (ctr_ld) ctr_q <= ctr_val;
      if (start) begin
        run_q   <= 1'b1;
        first_q <= 1'b1;
        why_q   <= WHY_NONE;
      end
    end else if (bp_hit) begin
      run_q <= 1'b0;
      why_q <= WHY_BP;
    end else begin
      first_q <= 1'b0;
      pres_q  <= fetch;
      ctr_q   <= nxt;
      case (op)
        3'b000: ctr_q <= opnd[ADDR_W-1:0];
        3'b001: ctr_q <= nxt + opnd[ADDR_W-1:0];
        3'b010: acc_q <= -opnd;
        3'b100,
        3'b101: acc_q <= acc_q - opnd;
        3'b110: ctr_q <= nxt + {{(ADDR_W-1){1'b0}}, neg};
        3'b111: begin
          run_q <= 1'b0;
          why_q <= WHY_STOP;
        end
        default: ;
      endcase
    end
  end

  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start) |=> (!halted && halt_why == WHY_NONE));

  a_r2_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted);

  a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'b111) |=> (halted && halt_why == WHY_STOP && ctr == $past(nxt)));

  a_r8_bp_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |=> (halted && halt_why == WHY_BP && $stable(ctr) && $stable(acc) && $stable(pres)));

  a_r6_no_skip_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'b110 && !neg) |=> (ctr == $past(nxt)));

  a_r10_ctr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && ctr_ld) |=> (ctr == $past(ctr_val)));

  a_r9_deposit: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && dbg_we) |=> (mem[$past(dbg_addr)] == $past(dbg_wdata)));

  a_r2_halt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (halt_why != WHY_NONE));
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bp_en = 1'b0, dbg_we = 1'b0, ctr_ld = 1'b0;
  logic [4:0]  bp_addr = '0, dbg_addr = '0, ctr_val = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata, acc, pres;
  logic        halted;
  logic [1:0]  halt_why;
  logic [4:0]  ctr;
  int checks = 0, errors = 0, cycles = 0;

  acc_cpu u0 (.clk(clk), .rst_n(rst_n), .start(start), .bp_en(bp_en), .bp_addr(bp_addr),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .ctr_ld(ctr_ld), .ctr_val(ctr_val), .halted(halted), .halt_why(halt_why),
    .acc(acc), .ctr(ctr), .pres(pres));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ins(input logic [2:0] op, input logic [4:0] a);
    return {16'h0, op, 8'h0, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic poke(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk); dbg_we = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    dbg_addr = a; #1; d = dbg_rdata;
  endtask

  task automatic setctr(input logic [4:0] v);
    @(negedge clk); ctr_ld = 1'b1; ctr_val = v;
    @(negedge clk); ctr_ld = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_halt(input string tag);
    for (int i = 0; i < 1000 && !halted; i++) @(negedge clk);
    chk({tag, " halted"}, {31'b0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 halted", {31'b0, halted}, 32'd1);
    chk("R1 why", {30'b0, halt_why}, 32'd0);
    chk("R1 acc", acc, 32'd0);
    chk("R1 ctr", {27'b0, ctr}, 32'd0);
    chk("R1 pres", pres, 32'd0);
    peek(5'd17, d); chk("R1 store zero", d, 32'd0);
  endtask

  task automatic t_arith();
    logic [31:0] d;
    poke(5'd20, 32'd5); poke(5'd21, 32'd3); poke(5'd22, 32'd2);
    poke(5'd1, ins(3'b010, 5'd20));
    poke(5'd2, ins(3'b100, 5'd21));
    poke(5'd3, ins(3'b101, 5'd22));
    poke(5'd4, ins(3'b011, 5'd23));
    poke(5'd5, ins(3'b111, 5'd0));
    setctr(5'd0);
    pulse_start();
    chk("R2 running after start", {31'b0, halted}, 32'd0);
    chk("R2 ctr before first step", {27'b0, ctr}, 32'd0);
    @(negedge clk);
    chk("R2 ctr preincrement", {27'b0, ctr}, 32'd1);
    chk("R2 pres fetched", pres, ins(3'b010, 5'd20));
    chk("R4 load negated", acc, 32'hFFFF_FFFB);
    wait_halt("R7");
    chk("R5 subtract both codes", acc, 32'hFFFF_FFF6);
    chk("R7 why stop", {30'b0, halt_why}, 32'd1);
    chk("R7 ctr at stop", {27'b0, ctr}, 32'd5);
    chk("R7 pres stop", pres, ins(3'b111, 5'd0));
    peek(5'd23, d); chk("R4 store", d, 32'hFFFF_FFF6);
  endtask

  task automatic t_jumps();
    poke(5'd24, 32'hFFFF_FFEB);
    poke(5'd25, 32'd3);
    poke(5'd9, ins(3'b000, 5'd24));
    poke(5'd10, ins(3'b111, 5'd0));
    poke(5'd12, ins(3'b001, 5'd25));
    poke(5'd13, ins(3'b111, 5'd0));
    poke(5'd16, ins(3'b111, 5'd0));
    setctr(5'd8);
    pulse_start(); wait_halt("R3");
    chk("R3 indirect then relative", {27'b0, ctr}, 32'd16);
    poke(5'd26, 32'd4);
    poke(5'd30, ins(3'b001, 5'd26));
    poke(5'd3, ins(3'b111, 5'd0));
    setctr(5'd29);
    pulse_start(); wait_halt("R3");
    chk("R3 relative wraps", {27'b0, ctr}, 32'd3);
    poke(5'd0, ins(3'b111, 5'd0));
    setctr(5'd31);
    pulse_start(); wait_halt("R2");
    chk("R2 counter wraps to 0", {27'b0, ctr}, 32'd0);
  endtask

  task automatic t_skip();
    poke(5'd17, ins(3'b110, 5'd9));
    poke(5'd18, ins(3'b111, 5'd0));
    poke(5'd19, ins(3'b111, 5'd0));
    setctr(5'd16);
    pulse_start(); wait_halt("R6");
    chk("R6 skip when negative", {27'b0, ctr}, 32'd19);
    poke(5'd27, 32'hFFFF_FFF9);
    poke(5'd28, ins(3'b010, 5'd27));
    poke(5'd29, ins(3'b110, 5'd0));
    poke(5'd30, ins(3'b111, 5'd0));
    poke(5'd31, ins(3'b111, 5'd0));
    setctr(5'd27);
    pulse_start(); wait_halt("R6");
    chk("R6 acc positive", acc, 32'd7);
    chk("R6 no skip when positive", {27'b0, ctr}, 32'd30);
  endtask

  task automatic t_break();
    poke(5'd20, 32'd5); poke(5'd21, 32'd3);
    poke(5'd1, ins(3'b010, 5'd20));
    poke(5'd2, ins(3'b010, 5'd21));
    poke(5'd3, ins(3'b111, 5'd0));
    setctr(5'd0);
    @(negedge clk); bp_en = 1'b1; bp_addr = 5'd1;
    pulse_start(); wait_halt("R8");
    chk("R8 why breakpoint", {30'b0, halt_why}, 32'd2);
    chk("R8 ctr held", {27'b0, ctr}, 32'd1);
    chk("R8 acc before bp", acc, 32'hFFFF_FFFB);
    chk("R8 no fetch at bp", pres, ins(3'b010, 5'd20));
    pulse_start(); wait_halt("R8");
    chk("R8 resume passes bp", acc, 32'hFFFF_FFFD);
    chk("R8 resume stops", {30'b0, halt_why}, 32'd1);
    chk("R8 resume ctr", {27'b0, ctr}, 32'd3);
    bp_en = 1'b0;
  endtask

  task automatic t_debug_running();
    logic [31:0] d;
    poke(5'd12, 32'h0000_1111);
    poke(5'd5, ins(3'b000, 5'd6));
    poke(5'd6, 32'd4);
    setctr(5'd4);
    pulse_start();
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 5'd12; dbg_wdata = 32'h0000_ABCD;
    ctr_ld = 1'b1; ctr_val = 5'd9;
    @(negedge clk);
    dbg_we = 1'b0; ctr_ld = 1'b0;
    chk("R9 still running", {31'b0, halted}, 32'd0);
    bp_en = 1'b1; bp_addr = 5'd4;
    wait_halt("R9");
    bp_en = 1'b0;
    chk("R10 ctr load ignored running", {27'b0, ctr}, 32'd4);
    peek(5'd12, d); chk("R9 deposit ignored running", d, 32'h0000_1111);
  endtask

  task automatic t_same_cycle();
    logic [31:0] a0;
    poke(5'd20, 32'd5);
    poke(5'd8, ins(3'b010, 5'd20));
    poke(5'd21, ins(3'b111, 5'd0));
    setctr(5'd20);
    a0 = acc;
    @(negedge clk);
    start = 1'b1; dbg_we = 1'b1; dbg_addr = 5'd8; dbg_wdata = ins(3'b111, 5'd0);
    ctr_ld = 1'b1; ctr_val = 5'd7;
    @(negedge clk);
    start = 1'b0; dbg_we = 1'b0; ctr_ld = 1'b0;
    wait_halt("R11");
    chk("R11 ctr from load", {27'b0, ctr}, 32'd8);
    chk("R11 deposited stop ran", pres, ins(3'b111, 5'd0));
    chk("R11 acc untouched", acc, a0);
    chk("R11 why stop", {30'b0, halt_why}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_jumps();
    t_skip();
    t_break();
    t_debug_running();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule